// File: doc/BRIEF.md
# Frequency Offset Capture and Clamp Controller

This block holds the correction term of an automatic frequency correction loop. An external estimator measures the carrier frequency error and reports each new estimate as a signed 8-bit value with a one-cycle done pulse. The controller decides, according to a programmed capture policy, whether that estimate becomes the stored frequency offset. It saturates the stored value to a programmable window and presents it, gated by an enable, as the term to be added to a synthesizer frequency control word.

A host programs the block with 16-bit command words. Only words whose high byte is 0xC4 are taken. The low byte sets the fields listed below, and each field takes effect from the clock edge after the word is accepted. The controller also drives the estimator's enable and its double-length (fine) measurement request.

Low byte layout: bits 7..6 capture policy, bits 5..4 window, bit 3 strobe, bit 2 fine, bit 1 output enable, bit 0 estimator enable.

Top module: `afc_offset_ctrl`

## Requirements
- R1: After reset the low byte reads as 0xF7: policy 11, window 11, strobe 0, fine 1, output enable 1, estimator enable 1. The stored offset is 0, so `pll_offset` is 0, and `est_enable` and `est_fine` are both 1.
- R2: A command is accepted only in a cycle with `cmd_valid` high and `cmd_word[15:8]` equal to 0xC4. Any other word, or a word without `cmd_valid`, changes nothing. A capture decided on the edge that accepts a command uses the settings that were in force before that edge.
- R3: Policy 00 (host strobe). Accepting a command with bit 3 = 1 while the held strobe bit is 0 loads the saturated latest estimate into the offset on that edge. The latest estimate is the value of the last done pulse seen while the estimator was enabled, and it is 0 after reset. Rewriting bit 3 = 1 while it is already 1 captures nothing. Done pulses never load the offset directly under this policy.
- R4: Policy 01 (once). The first done pulse under this policy loads the saturated estimate and sets a flag. The flag blocks every later capture under policy 01 until reset, even after the policy has been changed away and back.
- R5: Policy 10 (valid data only). A done pulse loads the saturated estimate only while `vdi` is high. A falling edge of `vdi` (high in one cycle, low in the next) clears the offset to 0.
- R6: Policy 11 (always). Every done pulse loads the saturated estimate.
- R7: Window codes: 00 no limit, 01 limits to -16..+15, 10 limits to -8..+7, 11 limits to -4..+3. Values are in two's complement.
- R8: Saturation is applied when a value is loaded. Changing the window leaves an offset that is already stored unchanged.
- R9: While estimator enable (bit 0) is 0, `est_enable` is 0, and neither the offset, the latest estimate nor the once flag changes.
- R10: `pll_offset` equals the stored offset while output enable (bit 1) is 1, and it is 0 while bit 1 is 0.
- R11: `est_fine` follows bit 2 of the last accepted command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command word qualifier |
| cmd_word | input | 16 | Command word; high byte must be 0xC4 |
| est_done | input | 1 | One-cycle pulse: a new estimate is on `est_err` |
| est_err | input | 8 | Signed frequency error estimate in steps |
| vdi | input | 1 | Valid data present indication |
| est_enable | output | 1 | Enable to the estimator |
| est_fine | output | 1 | Double-length measurement request to the estimator |
| pll_offset | output | 8 | Signed offset for the frequency control word |

## Verification
The bench attacks four areas. The first is the strobe edge. A design that captures on level rather than edge would reload the offset on a repeated write. A design that captures the live estimate instead of the held one would show a value that arrived while the estimator was disabled. The second is the sticky once flag across policy changes: clearing it on a mode switch lets a second estimate through. The third is the `vdi` fall clear and the gating of done pulses by `vdi`. The fourth is the three window bounds at both signs and a window change after loading. An off-by-one bound, or saturation applied at the output instead of at capture, moves the visible offset.

// File: rtl/afc_pkg.sv
package afc_pkg;
  localparam int CMD_W = 16;
  localparam int CFG_W = 8;
  localparam logic [7:0] CMD_PREFIX = 8'hC4;
  localparam logic [CFG_W-1:0] CFG_RESET = 8'hF7;

  typedef enum logic [1:0] {
    CAP_STROBE = 2'b00,
    CAP_ONCE   = 2'b01,
    CAP_VALID  = 2'b10,
    CAP_ALWAYS = 2'b11
  } cap_mode_e;

  typedef struct packed {
    cap_mode_e  mode;
    logic [1:0] window;
    logic       strobe;
    logic       fine;
    logic       out_en;
    logic       calc_en;
  } afc_cfg_t;
endpackage

// File: rtl/afc_rst_sync.sv
module afc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/afc_cmd_reg.sv
module afc_cmd_reg
  import afc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_word,
  output afc_cfg_t         cfg_q,
  output logic             strobe_rise
);
  logic     hit;
  afc_cfg_t cfg_d;

  assign hit         = cmd_valid && (cmd_word[CMD_W-1:CFG_W] == CMD_PREFIX);
  assign strobe_rise = hit && cmd_word[3] && !cfg_q.strobe;

  always_comb begin
    cfg_d = afc_cfg_t'(cmd_word[CFG_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cfg_q <= afc_cfg_t'(CFG_RESET);
    else if (hit) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/afc_capture.sv
module afc_capture
  import afc_pkg::*;
#(
  parameter int ERR_W    = 8,
  parameter int LIM_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  afc_cfg_t         cfg,
  input  logic             strobe_rise,
  input  logic             est_done,
  input  logic [ERR_W-1:0] est_err,
  input  logic             vdi,
  output logic [ERR_W-1:0] offset_q,
  output logic             once_q,
  output logic             vdi_q
);
  localparam logic signed [ERR_W-1:0] HI_WIDE = ERR_W'((1 << LIM_LOG2) - 1);
  localparam logic signed [ERR_W-1:0] LO_WIDE = ERR_W'(-(1 << LIM_LOG2));
  localparam logic signed [ERR_W-1:0] HI_MID  = ERR_W'((1 << (LIM_LOG2 - 1)) - 1);
  localparam logic signed [ERR_W-1:0] LO_MID  = ERR_W'(-(1 << (LIM_LOG2 - 1)));
  localparam logic signed [ERR_W-1:0] HI_NAR  = ERR_W'((1 << (LIM_LOG2 - 2)) - 1);
  localparam logic signed [ERR_W-1:0] LO_NAR  = ERR_W'(-(1 << (LIM_LOG2 - 2)));

  logic [ERR_W-1:0]        latest_q, latest_d, offset_d, cap_src, cap_sat;
  logic signed [ERR_W-1:0] hi_lim, lo_lim;
  logic                    once_d, lim_on, latest_load, offset_load, once_load;

  // window bounds
  always_comb begin
    lim_on = 1'b1;
    hi_lim = HI_NAR;
    lo_lim = LO_NAR;
    unique case (cfg.window)
      2'b00: lim_on = 1'b0;
      2'b01: begin hi_lim = HI_WIDE; lo_lim = LO_WIDE; end
      2'b10: begin hi_lim = HI_MID;  lo_lim = LO_MID;  end
      2'b11: begin hi_lim = HI_NAR;  lo_lim = LO_NAR;  end
    endcase
  end

  // one saturator shared by all policies
  assign cap_src = (cfg.mode == CAP_STROBE) ? latest_q : est_err;

  always_comb begin
    cap_sat = cap_src;
    if (lim_on) begin
      if ($signed(cap_src) > hi_lim)      cap_sat = hi_lim;
      else if ($signed(cap_src) < lo_lim) cap_sat = lo_lim;
    end
  end

  // next-state decision
  always_comb begin
    latest_d    = est_err;
    offset_d    = cap_sat;
    once_d      = 1'b1;
    latest_load = cfg.calc_en && est_done;
    offset_load = 1'b0;
    once_load   = 1'b0;
    if (cfg.calc_en) begin
      unique case (cfg.mode)
        CAP_STROBE: offset_load = strobe_rise;
        CAP_ONCE: begin
          offset_load = est_done && !once_q;
          once_load   = est_done && !once_q;
        end
        CAP_VALID: begin
          if (vdi_q && !vdi) begin
            offset_load = 1'b1;
            offset_d    = '0;
          end else begin
            offset_load = vdi && est_done;
          end
        end
        CAP_ALWAYS: offset_load = est_done;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latest_q <= '0;
      offset_q <= '0;
      once_q   <= 1'b0;
      vdi_q    <= 1'b0;
    end else begin
      vdi_q <= vdi;
      if (latest_load) latest_q <= latest_d;
      if (offset_load) offset_q <= offset_d;
      if (once_load)   once_q   <= once_d;
    end
  end
endmodule

// File: rtl/afc_offset_ctrl.sv
module afc_offset_ctrl
  import afc_pkg::*;
#(
  parameter int ERR_W    = 8,
  parameter int LIM_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             est_done,
  input  logic [ERR_W-1:0] est_err,
  input  logic             vdi,
  output logic             est_enable,
  output logic             est_fine,
  output logic [ERR_W-1:0] pll_offset
);
  logic             rst_sync_n;
  afc_cfg_t         cfg_q;
  logic             strobe_rise;
  logic [ERR_W-1:0] offset_q;
  logic             once_q;
  logic             vdi_q;

  afc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  afc_cmd_reg u_cmd (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cmd_valid   (cmd_valid),
    .cmd_word    (cmd_word),
    .cfg_q       (cfg_q),
    .strobe_rise (strobe_rise)
  );

  afc_capture #(.ERR_W(ERR_W), .LIM_LOG2(LIM_LOG2)) u_cap (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cfg         (cfg_q),
    .strobe_rise (strobe_rise),
    .est_done    (est_done),
    .est_err     (est_err),
    .vdi         (vdi),
    .offset_q    (offset_q),
    .once_q      (once_q),
    .vdi_q       (vdi_q)
  );

  assign est_enable = cfg_q.calc_en;
  assign est_fine   = cfg_q.fine;
  assign pll_offset = cfg_q.out_en ? offset_q : '0;
endmodule

// File: rtl/afc_offset_ctrl_chk.sv
module afc_offset_ctrl_chk #(
  parameter int ERR_W    = 8,
  parameter int LIM_LOG2 = 4
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [7:0]       cfg_q,
  input logic [ERR_W-1:0] offset_q,
  input logic             once_q,
  input logic             vdi_q,
  input logic             vdi,
  input logic [ERR_W-1:0] pll_offset
);
  function automatic logic fits(input logic [ERR_W-1:0] v, input logic [1:0] w);
    int p;
    if (w == 2'b00) return 1'b1;
    p = 1 << (LIM_LOG2 + 1 - int'(w));
    return ($signed(v) <= p - 1) && ($signed(v) >= -p);
  endfunction

  // R10
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_q[1] |-> pll_offset == '0);

  // R7
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(offset_q) |-> fits(offset_q, $past(cfg_q[5:4])));

  // R9
  calc_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_q[0] |=> $stable(offset_q));

  // R4
  once_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    once_q |=> once_q);

  // R4
  once_block_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_q[7:6] == 2'b01 && once_q) |=> $stable(offset_q));

  // R5
  vdi_fall_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_q[7:6] == 2'b10 && cfg_q[0] && vdi_q && !vdi) |=> offset_q == '0);
endmodule

bind afc_offset_ctrl afc_offset_ctrl_chk #(.ERR_W(ERR_W), .LIM_LOG2(LIM_LOG2)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cfg_q      (cfg_q),
  .offset_q   (offset_q),
  .once_q     (once_q),
  .vdi_q      (vdi_q),
  .vdi        (vdi),
  .pll_offset (pll_offset)
);

// File: tb/afc_offset_ctrl_test.sv
module afc_offset_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [15:0] cmd_word;
  logic        est_done;
  logic [7:0]  est_err;
  logic        vdi;
  logic        est_enable, est_fine;
  logic [7:0]  pll_offset;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit armed = 1'b0;
  bit done_flag = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int m_mode, m_win, m_stb, m_fine, m_oe, m_en, m_off, m_lat, m_once, m_vprev;
  int t_off, t_lat, t_once, t_e;
  bit t_hit;

  always #5 clk = ~clk;

  afc_offset_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .est_done(est_done), .est_err(est_err), .vdi(vdi),
    .est_enable(est_enable), .est_fine(est_fine), .pll_offset(pll_offset)
  );

  function automatic int sat(input int v, input int w);
    int p;
    if (w == 0) return v;
    p = 32 >> w;
    if (v > p - 1) return p - 1;
    if (v < -p) return -p;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 3; m_win = 3; m_stb = 0; m_fine = 1; m_oe = 1; m_en = 1;
      m_off = 0; m_lat = 0; m_once = 0; m_vprev = 0;
    end else begin
      t_e = $signed(est_err);
      t_hit = cmd_valid && (cmd_word[15:8] == 8'hC4);
      t_off = m_off; t_lat = m_lat; t_once = m_once;
      if (m_en != 0) begin
        if (est_done) t_lat = t_e;
        case (m_mode)
          0: if (t_hit && cmd_word[3] && m_stb == 0) t_off = sat(m_lat, m_win);
          1: if (est_done && m_once == 0) begin t_off = sat(t_e, m_win); t_once = 1; end
          2: if (m_vprev != 0 && !vdi) t_off = 0;
             else if (vdi && est_done) t_off = sat(t_e, m_win);
          default: if (est_done) t_off = sat(t_e, m_win);
        endcase
      end
      m_vprev = vdi;
      if (t_hit) begin
        m_mode = cmd_word[7:6]; m_win = cmd_word[5:4]; m_stb = cmd_word[3];
        m_fine = cmd_word[2]; m_oe = cmd_word[1]; m_en = cmd_word[0];
      end
      m_off = t_off; m_lat = t_lat; m_once = t_once;
    end
  end

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (armed && !done_flag) begin
      int exp_off;
      exp_off = (m_oe != 0) ? m_off : 0;
      compared++;
      if ($signed(pll_offset) != exp_off || est_enable != m_en[0] || est_fine != m_fine[0]) begin
        mismatched++;
        $display("FAIL %s model: offset=%0d en=%0b fine=%0b expected offset=%0d en=%0b fine=%0b",
                 cur_req, $signed(pll_offset), est_enable, est_fine, exp_off, m_en[0], m_fine[0]);
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done_flag) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      finish_run();
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic send(input logic [7:0] low, input logic [7:0] hi = 8'hC4, input logic v = 1'b1);
    @(negedge clk);
    cmd_valid = v; cmd_word = {hi, low};
    @(negedge clk);
    cmd_valid = 1'b0; cmd_word = '0;
  endtask

  task automatic estimate(input int e);
    @(negedge clk);
    est_done = 1'b1; est_err = 8'(e);
    @(negedge clk);
    est_done = 1'b0; est_err = '0;
  endtask

  task automatic set_vdi(input logic v);
    @(negedge clk);
    vdi = v;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_word = '0;
    est_done = 1'b0; est_err = '0; vdi = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    armed = 1'b1;

    cur_req = "R1";
    check("R1 offset", $signed(pll_offset), 0);
    check("R1 est_enable", est_enable, 1);
    check("R1 est_fine", est_fine, 1);

    cur_req = "R6";
    estimate(2);
    check("R6 load 2", $signed(pll_offset), 2);
    cur_req = "R7";
    estimate(-100);
    check("R7 narrow low", $signed(pll_offset), -4);

    cur_req = "R11";
    send(8'hC3);                       // policy 11, no window, fine 0
    check("R11 fine off", est_fine, 0);
    cur_req = "R6";
    estimate(100);
    check("R6 unlimited", $signed(pll_offset), 100);
    cur_req = "R8";
    send(8'hF3);                       // narrow window
    check("R8 stored kept", $signed(pll_offset), 100);

    cur_req = "R2";
    send(8'h00, 8'hC5, 1'b1);
    check("R2 wrong prefix", $signed(pll_offset), 100);
    send(8'h00, 8'hC4, 1'b0);
    check("R2 no valid", est_enable, 1);

    cur_req = "R7";
    send(8'hD3);
    estimate(50);
    check("R7 wide high", $signed(pll_offset), 15);
    estimate(-50);
    check("R7 wide low", $signed(pll_offset), -16);
    send(8'hE3);
    estimate(50);
    check("R7 mid high", $signed(pll_offset), 7);
    estimate(-50);
    check("R7 mid low", $signed(pll_offset), -8);

    cur_req = "R10";
    send(8'hE1);
    check("R10 gated", $signed(pll_offset), 0);
    send(8'hE3);
    check("R10 ungated", $signed(pll_offset), -8);

    cur_req = "R3";
    send(8'h03);                       // strobe policy, no window
    estimate(20);
    check("R3 done ignored", $signed(pll_offset), -8);
    send(8'h0B);
    check("R3 strobe edge", $signed(pll_offset), 20);
    estimate(30);
    send(8'h0B);
    check("R3 level no capture", $signed(pll_offset), 20);
    send(8'h03);
    send(8'h0B);
    check("R3 second edge", $signed(pll_offset), 30);

    cur_req = "R9";
    send(8'hF3);
    estimate(25);
    check("R9 setup", $signed(pll_offset), 3);
    send(8'hF2);
    check("R9 est_enable low", est_enable, 0);
    estimate(40);
    check("R9 hold", $signed(pll_offset), 3);
    send(8'h03);
    send(8'h0B);
    check("R9 latest kept", $signed(pll_offset), 25);

    cur_req = "R4";
    send(8'h43);
    estimate(9);
    check("R4 first", $signed(pll_offset), 9);
    estimate(11);
    check("R4 blocked", $signed(pll_offset), 9);
    send(8'hC3);
    estimate(12);
    check("R4 other policy", $signed(pll_offset), 12);
    send(8'h43);
    estimate(13);
    check("R4 still sticky", $signed(pll_offset), 12);

    cur_req = "R5";
    send(8'h83);
    estimate(5);
    check("R5 no vdi", $signed(pll_offset), 12);
    set_vdi(1'b1);
    estimate(6);
    check("R5 vdi load", $signed(pll_offset), 6);
    set_vdi(1'b0);
    check("R5 fall clear", $signed(pll_offset), 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule